// File: doc/BRIEF.md
# Prioritized Interrupt Dispatch Unit

This block decides, one evaluation at a time, whether a pending interrupt is accepted by the core. If it is, the block produces every processor-state update that goes with acceptance. Each cycle in which `eval_i` is high, it compares the pending level with the current interrupt level and with the configured number of levels. It also tests whether any line that belongs to the pending level is both set and enabled.

An accepted high-priority interrupt (level 2 and above) has these effects:
- the PC and status word are saved into that level's own save registers;
- the status word is raised to the new level with exception mode set;
- the PC jumps to the level's vector.

An accepted level-1 interrupt is turned into a general exception instead. It is classed as user, kernel or double from the user-mode and exception-mode bits of the status word. It writes the level-1-interrupt cause code and sets exception mode. Vector addresses are parameters, and they can be relocated against a run-time vector base.

All results are registered. They appear in the cycle after the evaluation, together with a one-cycle `taken_o` pulse. The core applies the write enables in that cycle.

Top module: `irq_dispatch_unit`

## Requirements
- R1: An evaluation (`eval_i`=1) is taken only if the pending level is nonzero, greater than `cur_level_i`, and not greater than NUM_LEVELS, and some line is set in the mask of that level, in `int_set_i` and in `int_en_i` together. The mask of level L is at bits [(L-1)*NUM_LINES +: NUM_LINES] of `level_mask_i`. An interrupt that fails this test, or that arrives with `eval_i`=0, causes no output activity.
- R2: A taken level L>1 asserts bit L-1 of both `epc_we_o` and `eps_we_o`, sets `save_pc_o` to the PC and sets `eps_wdata_o` to the status word. It does not assert `depc_we_o`.
- R3: For a taken level L>1, `ps_wdata_o` equals the status word with bits [3:0] replaced by L and bit 4 (exception mode) set. `cause_we_o` stays low and `exc_class_o` is 0 (none).
- R4: A taken level L>1 always loads the PC (`pc_load_o`=1) with the vector of level L, after any relocation.
- R5: A taken level 1 writes cause code 4 (`cause_we_o`=1) and sets `ps_wdata_o` to the status word with bit 4 set. No `eps_we_o` bit is asserted.
- R6: A taken level 1 with status bit 4 already set is class 3 (double). Its PC goes to `depc_we_o` when HAS_DEPC=1, and to bit 0 of `epc_we_o` otherwise.
- R7: A taken level 1 with status bit 4 clear writes the PC through bit 0 of `epc_we_o`. It is class 1 (user) when status bit 5 is set and class 2 (kernel) otherwise.
- R8: With RELOC_EN=1, every jump target is the fixed vector minus DEFAULT_BASE plus `vec_base_i`. With RELOC_EN=0 it is the fixed vector.
- R9: A level-1 class whose fixed vector is 0 leaves `pc_load_o` low. All its other writes still take place.
- R10: Results appear in the cycle after the evaluation and last exactly one cycle. Whenever `taken_o` is low, every write enable and `pc_load_o` is low.
- R11: While `rst` is high, all outputs are zero from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluate the pending interrupt this cycle |
| pend_level_i | input | 3 | Pending interrupt level |
| cur_level_i | input | 4 | Current interrupt level of the core |
| level_mask_i | input | NUM_LEVELS*NUM_LINES | Lines that belong to each level |
| int_set_i | input | NUM_LINES | Interrupt-set register |
| int_en_i | input | NUM_LINES | Interrupt-enable register |
| status_i | input | DATA_W | Processor status word |
| pc_i | input | DATA_W | Current PC |
| vec_base_i | input | DATA_W | Run-time vector base |
| taken_o | output | 1 | One-cycle acceptance pulse |
| pc_load_o | output | 1 | Redirect PC |
| pc_next_o | output | DATA_W | Redirect target |
| save_pc_o | output | DATA_W | PC value for the save register being written |
| epc_we_o | output | NUM_LEVELS | Per-level exception-PC write enables |
| depc_we_o | output | 1 | Double-exception PC write enable |
| eps_we_o | output | NUM_LEVELS | Per-level saved-status write enables |
| eps_wdata_o | output | DATA_W | Saved-status data |
| ps_we_o | output | 1 | Status write enable |
| ps_wdata_o | output | DATA_W | New status word |
| cause_we_o | output | 1 | Exception-cause write enable |
| cause_o | output | 6 | Exception cause code |
| exc_class_o | output | 2 | 0 none, 1 user, 2 kernel, 3 double |

## Verification
The bench builds two instances with NUM_LEVELS=3 and NUM_LINES=4. The small sizes let it sweep every pending level 0..7 against every current level 0..7, all four mode-bit combinations and all sixteen set patterns.

- The first instance has a double-exception PC register and relocation enabled. It exercises the relocation arithmetic and the path that saves into the double-exception register.
- The second has neither, and gives the user class a zero vector. It covers the fallback save into the level-1 register and the case where no redirect takes place.

Levels above NUM_LEVELS fall inside the 3-bit pending range, so the out-of-range rejection is covered as well.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  localparam int IRQ_LVL_W    = 3;
  localparam int IRQ_VEC_SLOTS = 1 << IRQ_LVL_W;
  localparam int PS_LVL_W     = 4;
  localparam int PS_EXCM_BIT  = 4;
  localparam int PS_UM_BIT    = 5;
  localparam int CAUSE_W      = 6;
  localparam logic [CAUSE_W-1:0] CAUSE_LVL1_IRQ = 6'd4;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_USER   = 2'd1,
    CLS_KERNEL = 2'd2,
    CLS_DOUBLE = 2'd3
  } exc_class_e;
endpackage

// File: rtl/irq_take_qual.sv
module irq_take_qual
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int NUM_LINES  = 32
) (
  input  logic [IRQ_LVL_W-1:0]            pend_level_i,
  input  logic [PS_LVL_W-1:0]             cur_level_i,
  input  logic [NUM_LEVELS*NUM_LINES-1:0] level_mask_i,
  input  logic [NUM_LINES-1:0]            int_set_i,
  input  logic [NUM_LINES-1:0]            int_en_i,
  output logic                            take_o
);
  logic [NUM_LINES-1:0]     active;
  logic [IRQ_VEC_SLOTS-1:0] lvl_hit;
  logic                     above_cur;
  logic                     in_range;

  assign active = int_set_i & int_en_i;

  generate
    for (genvar l = 0; l < IRQ_VEC_SLOTS; l++) begin : g_lvl
      if (l >= 1 && l <= NUM_LEVELS) begin : g_real
        assign lvl_hit[l] = |(level_mask_i[(l-1)*NUM_LINES +: NUM_LINES] & active);
      end else begin : g_none
        assign lvl_hit[l] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    above_cur = {1'b0, pend_level_i} > cur_level_i;
    in_range  = (pend_level_i != '0) && (int'(pend_level_i) <= NUM_LEVELS);
    take_o    = above_cur && in_range && lvl_hit[pend_level_i];
  end
endmodule

// File: rtl/irq_vector_reloc.sv
module irq_vector_reloc #(
  parameter int                 DATA_W       = 32,
  parameter bit                 RELOC_EN     = 1'b1,
  parameter logic [DATA_W-1:0]  DEFAULT_BASE = '0
) (
  input  logic [DATA_W-1:0] fixed_vec_i,
  input  logic [DATA_W-1:0] vec_base_i,
  output logic [DATA_W-1:0] target_o
);
  generate
    if (RELOC_EN) begin : g_reloc
      assign target_o = fixed_vec_i - DEFAULT_BASE + vec_base_i;
    end else begin : g_fixed
      logic unused_base;
      assign unused_base = ^vec_base_i;
      assign target_o    = fixed_vec_i;
    end
  endgenerate
endmodule

// File: rtl/irq_state_update.sv
module irq_state_update
  import irq_dispatch_pkg::*;
#(
  parameter int                 NUM_LEVELS   = 6,
  parameter int                 DATA_W       = 32,
  parameter bit                 HAS_DEPC     = 1'b1,
  parameter bit                 RELOC_EN     = 1'b1,
  parameter logic [DATA_W-1:0]  DEFAULT_BASE = '0,
  parameter logic [IRQ_VEC_SLOTS-1:0][DATA_W-1:0] LEVEL_VEC = '0,
  parameter logic [DATA_W-1:0]  USER_VEC     = '0,
  parameter logic [DATA_W-1:0]  KERNEL_VEC   = '0,
  parameter logic [DATA_W-1:0]  DOUBLE_VEC   = '0
) (
  input  logic                  take_i,
  input  logic [IRQ_LVL_W-1:0]  pend_level_i,
  input  logic [DATA_W-1:0]     status_i,
  input  logic [DATA_W-1:0]     pc_i,
  input  logic [DATA_W-1:0]     vec_base_i,
  output logic                  pc_load_o,
  output logic [DATA_W-1:0]     pc_next_o,
  output logic [DATA_W-1:0]     save_pc_o,
  output logic [NUM_LEVELS-1:0] epc_we_o,
  output logic                  depc_we_o,
  output logic [NUM_LEVELS-1:0] eps_we_o,
  output logic [DATA_W-1:0]     eps_wdata_o,
  output logic                  ps_we_o,
  output logic [DATA_W-1:0]     ps_wdata_o,
  output logic                  cause_we_o,
  output logic [CAUSE_W-1:0]    cause_o,
  output exc_class_e            exc_class_o
);
  localparam logic [DATA_W-1:0] LVL_FIELD = DATA_W'((1 << PS_LVL_W) - 1);
  localparam logic [DATA_W-1:0] EXCM_MASK = DATA_W'(1) << PS_EXCM_BIT;

  exc_class_e           l1_class;
  logic [DATA_W-1:0]    lvl_fixed, cls_fixed;
  logic [DATA_W-1:0]    lvl_target, cls_target;
  logic [IRQ_LVL_W-1:0] lvl_m1;

  always_comb begin
    if (status_i[PS_EXCM_BIT])   l1_class = CLS_DOUBLE;
    else if (status_i[PS_UM_BIT]) l1_class = CLS_USER;
    else                          l1_class = CLS_KERNEL;
    unique case (l1_class)
      CLS_USER:   cls_fixed = USER_VEC;
      CLS_KERNEL: cls_fixed = KERNEL_VEC;
      default:    cls_fixed = DOUBLE_VEC;
    endcase
    lvl_fixed = LEVEL_VEC[pend_level_i];
    lvl_m1    = pend_level_i - IRQ_LVL_W'(1);
  end

  irq_vector_reloc #(.DATA_W(DATA_W), .RELOC_EN(RELOC_EN), .DEFAULT_BASE(DEFAULT_BASE))
    u_lvl_reloc (.fixed_vec_i(lvl_fixed), .vec_base_i(vec_base_i), .target_o(lvl_target));

  irq_vector_reloc #(.DATA_W(DATA_W), .RELOC_EN(RELOC_EN), .DEFAULT_BASE(DEFAULT_BASE))
    u_cls_reloc (.fixed_vec_i(cls_fixed), .vec_base_i(vec_base_i), .target_o(cls_target));

  always_comb begin
    pc_load_o   = 1'b0;
    pc_next_o   = '0;
    save_pc_o   = '0;
    epc_we_o    = '0;
    depc_we_o   = 1'b0;
    eps_we_o    = '0;
    eps_wdata_o = '0;
    ps_we_o     = 1'b0;
    ps_wdata_o  = '0;
    cause_we_o  = 1'b0;
    cause_o     = '0;
    exc_class_o = CLS_NONE;
    if (take_i) begin
      save_pc_o = pc_i;
      ps_we_o   = 1'b1;
      if (pend_level_i != IRQ_LVL_W'(1)) begin
        epc_we_o    = NUM_LEVELS'(1) << lvl_m1;
        eps_we_o    = NUM_LEVELS'(1) << lvl_m1;
        eps_wdata_o = status_i;
        ps_wdata_o  = (status_i & ~LVL_FIELD) | DATA_W'(pend_level_i) | EXCM_MASK;
        pc_load_o   = 1'b1;
        pc_next_o   = lvl_target;
      end else begin
        cause_we_o  = 1'b1;
        cause_o     = CAUSE_LVL1_IRQ;
        ps_wdata_o  = status_i | EXCM_MASK;
        exc_class_o = l1_class;
        if (l1_class == CLS_DOUBLE && HAS_DEPC) depc_we_o = 1'b1;
        else                                    epc_we_o  = NUM_LEVELS'(1);
        if (cls_fixed != '0) begin
          pc_load_o = 1'b1;
          pc_next_o = cls_target;
        end
      end
    end
  end
endmodule

// File: rtl/irq_dispatch_unit.sv
module irq_dispatch_unit
  import irq_dispatch_pkg::*;
#(
  parameter int                 NUM_LEVELS   = 6,
  parameter int                 NUM_LINES    = 32,
  parameter int                 DATA_W       = 32,
  parameter bit                 HAS_DEPC     = 1'b1,
  parameter bit                 RELOC_EN     = 1'b1,
  parameter logic [DATA_W-1:0]  DEFAULT_BASE = 32'h4000_0000,
  parameter logic [IRQ_VEC_SLOTS-1:0][DATA_W-1:0] LEVEL_VEC = {
    32'h4000_0380, 32'h4000_0340, 32'h4000_0300, 32'h4000_02C0,
    32'h4000_0280, 32'h4000_0240, 32'h0000_0000, 32'h0000_0000},
  parameter logic [DATA_W-1:0]  USER_VEC     = 32'h4000_0100,
  parameter logic [DATA_W-1:0]  KERNEL_VEC   = 32'h4000_0140,
  parameter logic [DATA_W-1:0]  DOUBLE_VEC   = 32'h4000_0180
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            eval_i,
  input  logic [IRQ_LVL_W-1:0]            pend_level_i,
  input  logic [PS_LVL_W-1:0]             cur_level_i,
  input  logic [NUM_LEVELS*NUM_LINES-1:0] level_mask_i,
  input  logic [NUM_LINES-1:0]            int_set_i,
  input  logic [NUM_LINES-1:0]            int_en_i,
  input  logic [DATA_W-1:0]               status_i,
  input  logic [DATA_W-1:0]               pc_i,
  input  logic [DATA_W-1:0]               vec_base_i,
  output logic                            taken_o,
  output logic                            pc_load_o,
  output logic [DATA_W-1:0]               pc_next_o,
  output logic [DATA_W-1:0]               save_pc_o,
  output logic [NUM_LEVELS-1:0]           epc_we_o,
  output logic                            depc_we_o,
  output logic [NUM_LEVELS-1:0]           eps_we_o,
  output logic [DATA_W-1:0]               eps_wdata_o,
  output logic                            ps_we_o,
  output logic [DATA_W-1:0]               ps_wdata_o,
  output logic                            cause_we_o,
  output logic [CAUSE_W-1:0]              cause_o,
  output logic [1:0]                      exc_class_o
);
  logic                  qual_take, take;
  logic                  n_pc_load, n_depc_we, n_ps_we, n_cause_we;
  logic [DATA_W-1:0]     n_pc_next, n_save_pc, n_eps_wdata, n_ps_wdata;
  logic [NUM_LEVELS-1:0] n_epc_we, n_eps_we;
  logic [CAUSE_W-1:0]    n_cause;
  exc_class_e            n_class;

  irq_take_qual #(.NUM_LEVELS(NUM_LEVELS), .NUM_LINES(NUM_LINES)) u_qual (
    .pend_level_i (pend_level_i),
    .cur_level_i  (cur_level_i),
    .level_mask_i (level_mask_i),
    .int_set_i    (int_set_i),
    .int_en_i     (int_en_i),
    .take_o       (qual_take)
  );

  assign take = eval_i && qual_take;

  irq_state_update #(
    .NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W), .HAS_DEPC(HAS_DEPC),
    .RELOC_EN(RELOC_EN), .DEFAULT_BASE(DEFAULT_BASE), .LEVEL_VEC(LEVEL_VEC),
    .USER_VEC(USER_VEC), .KERNEL_VEC(KERNEL_VEC), .DOUBLE_VEC(DOUBLE_VEC)
  ) u_update (
    .take_i       (take),
    .pend_level_i (pend_level_i),
    .status_i     (status_i),
    .pc_i         (pc_i),
    .vec_base_i   (vec_base_i),
    .pc_load_o    (n_pc_load),
    .pc_next_o    (n_pc_next),
    .save_pc_o    (n_save_pc),
    .epc_we_o     (n_epc_we),
    .depc_we_o    (n_depc_we),
    .eps_we_o     (n_eps_we),
    .eps_wdata_o  (n_eps_wdata),
    .ps_we_o      (n_ps_we),
    .ps_wdata_o   (n_ps_wdata),
    .cause_we_o   (n_cause_we),
    .cause_o      (n_cause),
    .exc_class_o  (n_class)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o     <= 1'b0;
      pc_load_o   <= 1'b0;
      pc_next_o   <= '0;
      save_pc_o   <= '0;
      epc_we_o    <= '0;
      depc_we_o   <= 1'b0;
      eps_we_o    <= '0;
      eps_wdata_o <= '0;
      ps_we_o     <= 1'b0;
      ps_wdata_o  <= '0;
      cause_we_o  <= 1'b0;
      cause_o     <= '0;
      exc_class_o <= '0;
    end else begin
      taken_o     <= take;
      pc_load_o   <= n_pc_load;
      pc_next_o   <= n_pc_next;
      save_pc_o   <= n_save_pc;
      epc_we_o    <= n_epc_we;
      depc_we_o   <= n_depc_we;
      eps_we_o    <= n_eps_we;
      eps_wdata_o <= n_eps_wdata;
      ps_we_o     <= n_ps_we;
      ps_wdata_o  <= n_ps_wdata;
      cause_we_o  <= n_cause_we;
      cause_o     <= n_cause;
      exc_class_o <= n_class;
    end
  end
endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker
  import irq_dispatch_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int DATA_W     = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  eval_i,
  input logic [IRQ_LVL_W-1:0]  pend_level_i,
  input logic [PS_LVL_W-1:0]   cur_level_i,
  input logic [DATA_W-1:0]     status_i,
  input logic [DATA_W-1:0]     pc_i,
  input logic                  taken_o,
  input logic                  pc_load_o,
  input logic [DATA_W-1:0]     save_pc_o,
  input logic [NUM_LEVELS-1:0] epc_we_o,
  input logic                  depc_we_o,
  input logic [NUM_LEVELS-1:0] eps_we_o,
  input logic [DATA_W-1:0]     eps_wdata_o,
  input logic                  ps_we_o,
  input logic [DATA_W-1:0]     ps_wdata_o,
  input logic                  cause_we_o,
  input logic [CAUSE_W-1:0]    cause_o,
  input logic [1:0]            exc_class_o
);
  AST_TAKE_AFTER_EVAL: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> $past(eval_i)); // R10
  AST_NOT_ABOVE_CUR: assert property (@(posedge clk) disable iff (rst)
    (eval_i && ({1'b0, pend_level_i} <= cur_level_i)) |=> !taken_o); // R1
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    (eval_i && (int'(pend_level_i) > NUM_LEVELS)) |=> !taken_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !taken_o |-> (!ps_we_o && !cause_we_o && !pc_load_o && !depc_we_o
                  && epc_we_o == '0 && eps_we_o == '0)); // R10
  AST_ONE_PC_SAVE: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> ($countones({epc_we_o, depc_we_o}) == 1)); // R6
  AST_EXCM_RAISED: assert property (@(posedge clk) disable iff (rst)
    ps_we_o |-> ps_wdata_o[PS_EXCM_BIT]); // R5
  AST_L1_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (taken_o && exc_class_o != 2'd0) |-> (cause_we_o && cause_o == CAUSE_LVL1_IRQ
                                          && eps_we_o == '0)); // R5
  AST_HIGH_VECTORS: assert property (@(posedge clk) disable iff (rst)
    (taken_o && exc_class_o == 2'd0) |-> ($onehot0(eps_we_o) && eps_we_o != '0
                                          && pc_load_o && !cause_we_o)); // R4
  AST_STATUS_SAVED: assert property (@(posedge clk) disable iff (rst)
    (eps_we_o != '0) |-> (eps_wdata_o == $past(status_i))); // R2
  AST_PC_SAVED: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (save_pc_o == $past(pc_i))); // R2
endmodule

bind irq_dispatch_unit irq_dispatch_checker #(.NUM_LEVELS(NUM_LEVELS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .eval_i(eval_i), .pend_level_i(pend_level_i),
  .cur_level_i(cur_level_i), .status_i(status_i), .pc_i(pc_i),
  .taken_o(taken_o), .pc_load_o(pc_load_o), .save_pc_o(save_pc_o),
  .epc_we_o(epc_we_o), .depc_we_o(depc_we_o), .eps_we_o(eps_we_o),
  .eps_wdata_o(eps_wdata_o), .ps_we_o(ps_we_o), .ps_wdata_o(ps_wdata_o),
  .cause_we_o(cause_we_o), .cause_o(cause_o), .exc_class_o(exc_class_o)
);

// File: tb/test_irq_dispatch_unit.sv
module test_irq_dispatch_unit;
  localparam int NL = 3;
  localparam int NI = 4;
  localparam logic [31:0] BASE_A = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          eval;
  logic [2:0]    pend;
  logic [3:0]    cur;
  logic [NL*NI-1:0] lmask;
  logic [NI-1:0] iset, ien;
  logic [31:0]   status, pc, vbase;

  logic a_taken, a_pcl, a_depc, a_psw, a_cw; logic [31:0] a_pcn, a_spc, a_epsd, a_psd;
  logic [NL-1:0] a_epc, a_eps; logic [5:0] a_cause; logic [1:0] a_cls;
  logic b_taken, b_pcl, b_depc, b_psw, b_cw; logic [31:0] b_pcn, b_spc, b_epsd, b_psd;
  logic [NL-1:0] b_epc, b_eps; logic [5:0] b_cause; logic [1:0] b_cls;

  irq_dispatch_unit #(.NUM_LEVELS(NL), .NUM_LINES(NI), .HAS_DEPC(1'b1), .RELOC_EN(1'b1),
    .DEFAULT_BASE(BASE_A),
    .LEVEL_VEC({32'h0, 32'h0, 32'h0, 32'h0, 32'h1200, 32'h1100, 32'h0, 32'h0}),
    .USER_VEC(32'h1300), .KERNEL_VEC(32'h1400), .DOUBLE_VEC(32'h1500)
  ) i_irq_dispatch_unit (
    .clk(clk), .rst(rst), .eval_i(eval), .pend_level_i(pend), .cur_level_i(cur),
    .level_mask_i(lmask), .int_set_i(iset), .int_en_i(ien), .status_i(status),
    .pc_i(pc), .vec_base_i(vbase), .taken_o(a_taken), .pc_load_o(a_pcl),
    .pc_next_o(a_pcn), .save_pc_o(a_spc), .epc_we_o(a_epc), .depc_we_o(a_depc),
    .eps_we_o(a_eps), .eps_wdata_o(a_epsd), .ps_we_o(a_psw), .ps_wdata_o(a_psd),
    .cause_we_o(a_cw), .cause_o(a_cause), .exc_class_o(a_cls));

  irq_dispatch_unit #(.NUM_LEVELS(NL), .NUM_LINES(NI), .HAS_DEPC(1'b0), .RELOC_EN(1'b0),
    .DEFAULT_BASE(32'h0),
    .LEVEL_VEC({32'h0, 32'h0, 32'h0, 32'h0, 32'h2200, 32'h2100, 32'h0, 32'h0}),
    .USER_VEC(32'h0), .KERNEL_VEC(32'h2400), .DOUBLE_VEC(32'h2500)
  ) i_irq_dispatch_unit_b (
    .clk(clk), .rst(rst), .eval_i(eval), .pend_level_i(pend), .cur_level_i(cur),
    .level_mask_i(lmask), .int_set_i(iset), .int_en_i(ien), .status_i(status),
    .pc_i(pc), .vec_base_i(vbase), .taken_o(b_taken), .pc_load_o(b_pcl),
    .pc_next_o(b_pcn), .save_pc_o(b_spc), .epc_we_o(b_epc), .depc_we_o(b_depc),
    .eps_we_o(b_eps), .eps_wdata_o(b_epsd), .ps_we_o(b_psw), .ps_wdata_o(b_psd),
    .cause_we_o(b_cw), .cause_o(b_cause), .exc_class_o(b_cls));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected values, per configuration (is_a selects the first instance)
  logic e_taken, e_pcl, e_depc, e_psw, e_cw;
  logic [31:0] e_pcn, e_spc, e_epsd, e_psd;
  logic [NL-1:0] e_epc, e_eps; logic [5:0] e_cause; logic [1:0] e_cls;
  string t_save, t_ps, t_cause, t_pc;

  task automatic model(input bit is_a, input bit ev);
    logic [3:0] m;
    logic [31:0] fv;
    bit take;
    e_taken = 0; e_pcl = 0; e_depc = 0; e_psw = 0; e_cw = 0;
    e_pcn = 0; e_spc = 0; e_epsd = 0; e_psd = 0; e_epc = 0; e_eps = 0;
    e_cause = 0; e_cls = 0;
    t_save = "R10"; t_ps = "R10"; t_cause = "R10"; t_pc = "R10";
    m = (pend >= 1 && pend <= 3) ? lmask[(pend-1)*NI +: NI] : 4'h0;
    take = ev && (pend >= 1) && (pend <= NL) && ({1'b0, pend} > cur) && ((m & iset & ien) != 0);
    if (!take) return;
    e_taken = 1; e_spc = pc; e_psw = 1;
    if (pend > 1) begin
      t_save = "R2"; t_ps = "R3"; t_cause = "R3"; t_pc = is_a ? "R8" : "R4";
      e_epc = 3'(1 << (pend - 1)); e_eps = e_epc; e_epsd = status;
      e_psd = {status[31:5], 1'b1, 1'b0, pend};
      fv = is_a ? ((pend == 2) ? 32'h1100 : 32'h1200) : ((pend == 2) ? 32'h2100 : 32'h2200);
      e_pcl = 1; e_pcn = is_a ? fv - BASE_A + vbase : fv;
    end else begin
      t_ps = "R5"; e_cw = 1; e_cause = 6'd4; e_psd = status | 32'h10;
      if (status[4]) begin
        e_cls = 3; t_save = "R6"; t_cause = "R6";
        if (is_a) e_depc = 1; else e_epc = 3'b001;
        fv = is_a ? 32'h1500 : 32'h2500;
      end else begin
        t_save = "R7"; t_cause = "R7"; e_epc = 3'b001;
        e_cls = status[5] ? 2'd1 : 2'd2;
        fv = status[5] ? (is_a ? 32'h1300 : 32'h0) : (is_a ? 32'h1400 : 32'h2400);
      end
      t_pc = (fv == 0) ? "R9" : (is_a ? "R8" : "R4");
      if (fv != 0) begin
        e_pcl = 1; e_pcn = is_a ? fv - BASE_A + vbase : fv;
      end
    end
  endtask

  task automatic compare_a();
    chk(a_taken == e_taken, "R1 taken A", 32'(a_taken), 32'(e_taken));
    chk({a_epc, a_eps, a_depc} == {e_epc, e_eps, e_depc}, {t_save, " enables A"},
        32'({a_epc, a_eps, a_depc}), 32'({e_epc, e_eps, e_depc}));
    chk(a_spc == e_spc && a_epsd == e_epsd, {t_save, " save data A"}, a_spc ^ a_epsd, e_spc ^ e_epsd);
    chk(a_psw == e_psw && a_psd == e_psd, {t_ps, " status A"}, a_psd, e_psd);
    chk({a_cw, a_cause, a_cls} == {e_cw, e_cause, e_cls}, {t_cause, " cause/class A"},
        32'({a_cw, a_cause, a_cls}), 32'({e_cw, e_cause, e_cls}));
    chk(a_pcl == e_pcl && a_pcn == e_pcn, {t_pc, " pc A"}, a_pcn, e_pcn);
  endtask

  task automatic compare_b();
    chk(b_taken == e_taken, "R1 taken B", 32'(b_taken), 32'(e_taken));
    chk({b_epc, b_eps, b_depc} == {e_epc, e_eps, e_depc}, {t_save, " enables B"},
        32'({b_epc, b_eps, b_depc}), 32'({e_epc, e_eps, e_depc}));
    chk(b_spc == e_spc && b_epsd == e_epsd, {t_save, " save data B"}, b_spc ^ b_epsd, e_spc ^ e_epsd);
    chk(b_psw == e_psw && b_psd == e_psd, {t_ps, " status B"}, b_psd, e_psd);
    chk({b_cw, b_cause, b_cls} == {e_cw, e_cause, e_cls}, {t_cause, " cause/class B"},
        32'({b_cw, b_cause, b_cls}), 32'({e_cw, e_cause, e_cls}));
    chk(b_pcl == e_pcl && b_pcn == e_pcn, {t_pc, " pc B"}, b_pcn, e_pcn);
  endtask

  // hold expectations computed at drive time
  logic [3*32-1:0] unused_tb;
  task automatic step_and_check(input bit ev);
    logic sa_taken, sa_pcl, sa_depc, sa_psw, sa_cw;
    logic [31:0] sa_pcn, sa_spc, sa_epsd, sa_psd; logic [NL-1:0] sa_epc, sa_eps;
    logic [5:0] sa_cause; logic [1:0] sa_cls; string s1, s2, s3, s4;
    model(1'b1, ev);
    {sa_taken, sa_pcl, sa_depc, sa_psw, sa_cw} = {e_taken, e_pcl, e_depc, e_psw, e_cw};
    {sa_pcn, sa_spc, sa_epsd, sa_psd} = {e_pcn, e_spc, e_epsd, e_psd};
    {sa_epc, sa_eps, sa_cause, sa_cls} = {e_epc, e_eps, e_cause, e_cls};
    s1 = t_save; s2 = t_ps; s3 = t_cause; s4 = t_pc;
    model(1'b0, ev);
    @(negedge clk);
    compare_b();
    {e_taken, e_pcl, e_depc, e_psw, e_cw} = {sa_taken, sa_pcl, sa_depc, sa_psw, sa_cw};
    {e_pcn, e_spc, e_epsd, e_psd} = {sa_pcn, sa_spc, sa_epsd, sa_psd};
    {e_epc, e_eps, e_cause, e_cls} = {sa_epc, sa_eps, sa_cause, sa_cls};
    t_save = s1; t_ps = s2; t_cause = s3; t_pc = s4;
    compare_a();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int it;
    unused_tb = '0;
    lmask = {4'b1100, 4'b0110, 4'b0011};
    eval = 1'b1; pend = 3'd3; cur = 4'd0; iset = 4'hF; ien = 4'hF;
    status = 32'h0; pc = 32'h100; vbase = 32'h4000_0000;
    repeat (3) @(negedge clk);
    // R11: takeable inputs held during reset, outputs stay zero
    chk(a_taken == 0 && a_psw == 0 && a_pcn == 0 && a_spc == 0 && a_epc == 0,
        "R11 reset A", a_pcn, 32'h0);
    chk(b_taken == 0 && b_psw == 0 && b_pcn == 0 && b_spc == 0 && b_epc == 0,
        "R11 reset B", b_pcn, 32'h0);
    rst = 1'b0;
    // R1: takeable request with eval low is ignored
    eval = 1'b0; pend = 3'd2; status = 32'h0000_0001;
    step_and_check(1'b0);
    // R10: one evaluation gives exactly one pulse
    eval = 1'b1;
    step_and_check(1'b1);
    eval = 1'b0;
    step_and_check(1'b0);
    chk(a_taken == 0, "R10 pulse ends", 32'(a_taken), 32'h0);
    eval = 1'b1;
    it = 0;
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++)
        for (int s = 0; s < 4; s++)
          for (int st = 0; st < 16; st++)
            for (int e = 0; e < 2; e++) begin
              pend   = 3'(p);
              cur    = 4'(c);
              iset   = 4'(st);
              ien    = e[0] ? 4'hF : 4'b0101;
              status = 32'h5A00_0000 | (32'(s) << 4) | 32'(c);
              pc     = 32'h0010_0000 + (32'(it) << 2);
              vbase  = 32'h4000_0000 + (32'(p) << 16) + (32'(s) << 12);
              step_and_check(1'b1);
              it++;
            end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule